// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a byte-addressed serial memory. The fast system clock samples the two-wire bus lines. The block finds the bus framing events and collects bits into bytes. It checks the first byte of each transfer against a fixed device code and against three chip-select input pins. After that it either loads a word address and issues byte writes, or fetches bytes from a 32K x 8 synchronous-read memory port and shifts them out. The slave never drives the data line high. It only pulls the line low, through an output-enable, and the pad is an open-drain cell.

The page buffer and the timed commit of written data sit in a neighbouring block. This engine sends that block one write strobe per accepted data byte, and a commit pulse when a write transfer ends with Stop. While the neighbour reports that a write cycle is running, this engine acknowledges nothing. A master can therefore poll with control bytes until the cycle finishes.

Top module: `serial_mem_slave`

## Requirements
- R1: A Start (data line falls while clock line is high) restarts control-byte matching from any state, even in the middle of a byte. A Stop (data line rises while clock line is high) returns the engine to idle.
- R2: The control byte is sent MSB first. Bits 7:4 hold the device code 1010, bits 3:1 must equal `chip_sel[2:0]`, and bit 0 selects the direction (1 = read, 0 = write).
- R3: If the code or the chip-select bits do not match, the control byte gets no acknowledge. The engine then stays silent on every later byte until the next Start.
- R4: In a write transfer the next two bytes form the word address, high byte first. Bit 7 of the high byte is ignored, so the address is 15 bits wide.
- R5: For each byte the engine accepts, it holds `sda_oe` high through the whole high phase of the ninth clock. It releases `sda_oe` after the ninth clock falls.
- R6: Each data byte in a write transfer gives exactly one `mem_wr_en` pulse, carrying the byte and the current address. The next address then advances by one within its 64-byte page, so the low six bits wrap and the upper bits stay fixed.
- R7: Read bytes go out MSB first, each bit driven after the clock falls. The line is released for the ninth clock. A master acknowledge (line low) starts the next byte. A master no-acknowledge leaves the line released until Start or Stop.
- R8: The address pointer always names the location after the last byte read or written. A read with no address phase starts there, and reads step across the full 15 bits, wrapping from 0x7FFF to 0x0000.
- R9: While `wr_busy` is high, no byte is acknowledged, even a matching control byte, and no write strobe is issued.
- R10: `wr_commit` is a one-cycle pulse on a Stop that ends a write transfer in which at least one data byte was accepted. A Stop after only an address, or after a read, gives no pulse.
- R11: After reset, `sda_oe`, `mem_wr_en`, `mem_rd_en` and `wr_commit` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| chip_sel | input | 3 | Strap levels that the select bits must match |
| wr_busy | input | 1 | Internal write cycle running in the commit block |
| mem_addr | output | 15 | Word address for the current strobe |
| mem_rd_en | output | 1 | Read strobe; data is returned one cycle later |
| mem_rd_data | input | 8 | Read data from the memory port |
| mem_wr_en | output | 1 | Write strobe to the page buffer |
| mem_wr_data | output | 8 | Byte to write |
| wr_commit | output | 1 | Stop ended a write that carried data |

## Verification
The bench writes across a page end and checks that the address folds back to the start of the same page. A design that carried into the next page would send strobes with the wrong upper address bits. It reads across 0x7FFF, where a pointer that saturated or kept the page fold would return the wrong byte. It restarts in the middle of a byte and restarts between address phase and read. An engine that kept a stale bit count would then miss the acknowledge. It also sends mismatched control bytes followed by more bytes, and control bytes while busy. A design that acknowledged any of these, or stopped listening after them, would show up as a wrong acknowledge bit or as an unexpected write strobe.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;

  // transfer phase of the slave engine
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_AHI,
    PH_ALO,
    PH_WDATA,
    PH_RDATA
  } phase_t;

  localparam logic [3:0] DEV_CODE   = 4'b1010;
  localparam int         BYTE_W     = 8;
  localparam logic [3:0] ACK_SLOT   = 4'd9;
  localparam logic [3:0] LAST_BIT   = 4'd8;

endpackage

// File: rtl/sms_line_sync.sv
module sms_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0] raw;
  logic [1:0] synced;
  logic       scl_q, sda_q;

  assign raw = {scl_in, sda_in};

  for (genvar i = 0; i < 2; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[i]};
    end
    assign synced[i] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= synced[1];
      sda_q <= synced[0];
    end
  end

  logic scl_now;
  assign scl_now   = synced[1];
  assign sda_s     = synced[0];
  assign scl_rise  = scl_now & ~scl_q;
  assign scl_fall  = ~scl_now & scl_q;
  assign start_det = scl_now & scl_q & sda_q & ~synced[0];
  assign stop_det  = scl_now & scl_q & ~sda_q & synced[0];

endmodule

// File: rtl/sms_addr_ctr.sv
module sms_addr_ctr #(
  parameter int AW        = 15,
  parameter int PAGE_BITS = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step_page,
  input  logic          step_full,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] page_next;

  generate
    if (PAGE_BITS < AW) begin : g_paged
      assign page_next = {addr_q[AW-1:PAGE_BITS],
                          addr_q[PAGE_BITS-1:0] + PAGE_BITS'(1)};
    end else begin : g_flat
      assign page_next = addr_q + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)            addr_q <= '0;
    else if (load)      addr_q <= load_val;
    else if (step_page) addr_q <= page_next;
    else if (step_full) addr_q <= addr_q + AW'(1);
  end

  assign addr = addr_q;

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import serial_mem_pkg::*;
#(
  parameter int AW          = 15,
  parameter int PAGE_BITS   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic [2:0]    chip_sel,
  input  logic          wr_busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_en,
  input  logic [7:0]    mem_rd_data,
  output logic          mem_wr_en,
  output logic [7:0]    mem_wr_data,
  output logic          wr_commit
);

  localparam int HI_W = AW - BYTE_W;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  sms_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  phase_t          phase, nxt_phase;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic [HI_W-1:0] addr_hi;
  logic            master_nack;
  logic            wr_seen;
  logic            rd_pend;
  logic [7:0]      rd_hold;

  // event decode
  logic live, ev_decide, ev_end, ctrl_hit, load_rd;
  logic ctr_load, ctr_step_page, ctr_step_full;
  logic [AW-1:0] ctr_addr;

  always_comb begin
    live      = !start_det && !stop_det && (phase != PH_IDLE);
    ev_decide = live && scl_fall && (bitcnt == LAST_BIT);
    ev_end    = live && scl_fall && (bitcnt == ACK_SLOT);
    ctrl_hit  = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == chip_sel);
    load_rd   = (nxt_phase == PH_RDATA) &&
                !((phase == PH_RDATA) && master_nack);
    ctr_load      = ev_decide && (phase == PH_ALO) && !wr_busy;
    ctr_step_page = ev_decide && (phase == PH_WDATA) && !wr_busy;
    ctr_step_full = ev_end && load_rd;
  end

  sms_addr_ctr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (ctr_load),
    .load_val  ({addr_hi, shreg}),
    .step_page (ctr_step_page),
    .step_full (ctr_step_full),
    .addr      (ctr_addr)
  );

  // read data capture: memory answers one cycle after the strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      rd_hold <= '0;
    end else begin
      rd_pend <= mem_rd_en;
      if (rd_pend) rd_hold <= mem_rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      nxt_phase   <= PH_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      addr_hi     <= '0;
      master_nack <= 1'b0;
      wr_seen     <= 1'b0;
      sda_oe      <= 1'b0;
      mem_addr    <= '0;
      mem_rd_en   <= 1'b0;
      mem_wr_en   <= 1'b0;
      mem_wr_data <= '0;
      wr_commit   <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      wr_commit <= 1'b0;
      if (start_det) begin
        phase   <= PH_CTRL;
        bitcnt  <= '0;
        sda_oe  <= 1'b0;
        wr_seen <= 1'b0;
      end else if (stop_det) begin
        phase     <= PH_IDLE;
        bitcnt    <= '0;
        sda_oe    <= 1'b0;
        wr_commit <= wr_seen;
        wr_seen   <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < LAST_BIT) begin
            if (phase != PH_RDATA) shreg <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == ACK_SLOT && phase == PH_RDATA) begin
            master_nack <= sda_s;
          end
        end else if (scl_fall) begin
          if (phase == PH_RDATA && bitcnt != 4'd0 && bitcnt < LAST_BIT) begin
            shreg  <= {shreg[6:0], 1'b1};
            sda_oe <= ~shreg[6];
          end else if (bitcnt == LAST_BIT) begin
            bitcnt <= ACK_SLOT;
            unique case (phase)
              PH_CTRL: begin
                if (ctrl_hit && !wr_busy) begin
                  sda_oe <= 1'b1;
                  if (shreg[0]) begin
                    nxt_phase <= PH_RDATA;
                    mem_rd_en <= 1'b1;
                    mem_addr  <= ctr_addr;
                  end else begin
                    nxt_phase <= PH_AHI;
                  end
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_AHI: begin
                if (!wr_busy) begin
                  sda_oe    <= 1'b1;
                  addr_hi   <= shreg[HI_W-1:0];
                  nxt_phase <= PH_ALO;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_ALO: begin
                if (!wr_busy) begin
                  sda_oe    <= 1'b1;
                  nxt_phase <= PH_WDATA;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_WDATA: begin
                if (!wr_busy) begin
                  sda_oe      <= 1'b1;
                  mem_wr_en   <= 1'b1;
                  mem_wr_data <= shreg;
                  mem_addr    <= ctr_addr;
                  wr_seen     <= 1'b1;
                  nxt_phase   <= PH_WDATA;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_RDATA: begin
                sda_oe    <= 1'b0;
                mem_rd_en <= 1'b1;
                mem_addr  <= ctr_addr;
                nxt_phase <= PH_RDATA;
              end
              default: phase <= PH_IDLE;
            endcase
          end else if (bitcnt == ACK_SLOT) begin
            bitcnt <= '0;
            if (phase == PH_RDATA && master_nack) begin
              phase  <= PH_IDLE;
              sda_oe <= 1'b0;
            end else begin
              phase <= nxt_phase;
              if (load_rd) begin
                shreg  <= rd_hold;
                sda_oe <= ~rd_hold[7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/sms_checker.sv
module sms_checker (
  input logic clk,
  input logic rst,
  input logic scl_in,
  input logic sda_oe,
  input logic wr_busy,
  input logic mem_wr_en,
  input logic mem_rd_en,
  input logic wr_commit
);

  // R11
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sda_oe && !mem_wr_en && !mem_rd_en && !wr_commit));

  // R5
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_in);

  // R9
  busy_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> !wr_busy);

  // R6
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> !mem_wr_en);

  // R10
  commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr_en, mem_rd_en, wr_commit}));

endmodule

bind serial_mem_slave sms_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_in    (scl_in),
  .sda_oe    (sda_oe),
  .wr_busy   (wr_busy),
  .mem_wr_en (mem_wr_en),
  .mem_rd_en (mem_rd_en),
  .wr_commit (wr_commit)
);

// File: tb/sim_serial_mem_slave.sv
`timescale 1ns/100ps
module sim_serial_mem_slave;

  localparam int H = 16;
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] CW = {4'b1010, CS, 1'b0};
  localparam logic [7:0] CR = {4'b1010, CS, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wr_busy = 1'b0;
  logic sda_oe, mem_rd_en, mem_wr_en, wr_commit;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wr_data;
  logic [7:0]  rd_q = 8'h00;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;
  always #2.5 clk = ~clk;

  serial_mem_slave u0 (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .chip_sel(CS), .wr_busy(wr_busy), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_rd_data(rd_q), .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
    .wr_commit(wr_commit)
  );

  int tests = 0, fails = 0, cycles = 0, commits = 0;
  logic [7:0] dev_mem [int];
  logic [7:0] ref_mem [int];
  logic [22:0] exp_wr [$];
  int ptr = 0;

  function automatic logic [7:0] seed_val(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'hA5;
  endfunction
  function automatic logic [7:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_val(a);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device-side memory with one-cycle read
  always @(posedge clk) begin
    if (mem_rd_en)
      rd_q <= dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : seed_val(int'(mem_addr));
    if (mem_wr_en) dev_mem[int'(mem_addr)] = mem_wr_data;
  end

  // per-clock comparison against the model's write stream
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (wr_commit) commits++;
      if (mem_wr_en) begin
        if (exp_wr.size() == 0) chk(0, "R6 unexpected write", {mem_addr, mem_wr_data}, 0);
        else begin
          logic [22:0] e;
          e = exp_wr.pop_front();
          chk({mem_addr, mem_wr_data} == e, "R6 write addr/data", {mem_addr, mem_wr_data}, e);
        end
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic bus_start();
    sda_m = 1'b1; wait_n(H); scl_m = 1'b1; wait_n(H);
    sda_m = 1'b0; wait_n(H); scl_m = 1'b0; wait_n(4);
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; wait_n(H); scl_m = 1'b1; wait_n(H); sda_m = 1'b1; wait_n(H);
  endtask
  task automatic bit_x(input logic b, output logic r);
    sda_m = b; wait_n(H); scl_m = 1'b1; wait_n(H/2);
    r = sda_line; wait_n(H/2); scl_m = 1'b0; wait_n(4);
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(d[i], r);
    bit_x(1'b1, r);
    ack = ~r;
  endtask
  task automatic rbyte(input logic nack, output logic [7:0] d, output logic line9);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, r); d[i] = r; end
    bit_x(nack, line9);
  endtask
  task automatic wdata(input logic [7:0] d, string req);
    logic a;
    exp_wr.push_back({15'(ptr), d});
    ref_mem[ptr] = d;
    ptr = (ptr & 32'h7FC0) | ((ptr + 1) & 32'h3F);
    wbyte(d, a);
    chk(a, req, a, 1);
  endtask
  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic a;
    bus_start();
    wbyte(CW, a); chk(a, "R2 write control ack", a, 1);
    wbyte(hi, a); chk(a, "R4 high address ack", a, 1);
    wbyte(lo, a); chk(a, "R4 low address ack", a, 1);
    ptr = {hi[6:0], lo};
  endtask
  task automatic rd_expect(input logic nack, string req);
    logic [7:0] d; logic l9; logic [7:0] e;
    e = ref_rd(ptr);
    rbyte(nack, d, l9);
    chk(d == e, req, d, e);
    chk(l9 == nack, "R7 line released in ninth clock", l9, nack);
    ptr = (ptr + 1) & 32'h7FFF;
  endtask

  initial begin
    logic a; logic r; int c0;
    wait_n(5);
    chk(!sda_oe && !mem_wr_en && !mem_rd_en && !wr_commit, "R11 reset outputs",
        {sda_oe, mem_wr_en, mem_rd_en, wr_commit}, 0);
    rst = 1'b0;
    wait_n(5);
    chk(!sda_oe && !mem_wr_en && !mem_rd_en && !wr_commit, "R11 after reset",
        {sda_oe, mem_wr_en, mem_rd_en, wr_commit}, 0);

    // R3: wrong device code, then a valid-looking byte without a Start
    bus_start();
    wbyte({4'b1011, CS, 1'b0}, a); chk(!a, "R3 wrong code no ack", a, 0);
    wbyte(CW, a); chk(!a, "R3 silent until Start", a, 0);
    bus_stop();
    // R2: wrong chip select
    bus_start();
    wbyte({4'b1010, 3'b001, 1'b0}, a); chk(!a, "R2 chip select mismatch", a, 0);
    bus_stop();

    // R4/R6/R10: byte write, high address bit 7 set and ignored
    c0 = commits;
    set_addr(8'h92, 8'h34);
    chk(ptr == 32'h1234, "R4 bit 7 ignored", ptr, 32'h1234);
    wdata(8'h5C, "R5 data ack");
    bus_stop(); wait_n(6);
    chk(commits == c0 + 1, "R10 commit after write", commits, c0 + 1);

    // R8: current-address read follows the written location
    bus_start();
    wbyte(CR, a); chk(a, "R2 read control ack", a, 1);
    rd_expect(1'b1, "R8 current address read");
    wait_n(4);
    chk(!sda_oe, "R7 released after nack", sda_oe, 0);
    bus_stop(); wait_n(6);
    chk(commits == c0 + 1, "R10 no commit on read", commits, c0 + 1);

    // R1: repeated Start between address and read
    set_addr(8'h12, 8'h34);
    bus_start();
    wbyte(CR, a); chk(a, "R1 restart read ack", a, 1);
    rd_expect(1'b0, "R1 random read first byte");
    rd_expect(1'b0, "R7 sequential read");
    rd_expect(1'b1, "R7 last byte with nack");
    bus_stop(); wait_n(6);
    chk(commits == c0 + 1, "R10 no commit after address only", commits, c0 + 1);

    // R6: page write folding inside the page
    set_addr(8'h01, 8'h3E);
    wdata(8'h11, "R6 page byte 0");
    wdata(8'h22, "R6 page byte 1");
    wdata(8'h33, "R6 page fold byte");
    wdata(8'h44, "R6 page byte 3");
    bus_stop(); wait_n(6);
    chk(commits == c0 + 2, "R10 commit after page", commits, c0 + 2);
    chk(ptr == 32'h0102, "R6 pointer folded", ptr, 32'h0102);
    bus_start();
    wbyte(CR, a); chk(a, "R8 read ack", a, 1);
    rd_expect(1'b1, "R8 read after folded write");
    bus_stop();
    // verify folded data landed at page start
    set_addr(8'h01, 8'h00);
    bus_start();
    wbyte(CR, a);
    rd_expect(1'b0, "R6 folded byte at page start");
    rd_expect(1'b1, "R6 second folded byte");
    bus_stop();

    // R8: read wrap across the top of the array
    set_addr(8'h7F, 8'hFF);
    bus_start();
    wbyte(CR, a); chk(a, "R8 read ack at top", a, 1);
    rd_expect(1'b0, "R8 byte at 0x7FFF");
    rd_expect(1'b1, "R8 wrap to 0x0000");
    bus_stop();
    bus_start(); wbyte(CR, a);
    rd_expect(1'b1, "R8 continues at 0x0001");
    bus_stop();

    // R9: busy suppresses every acknowledge
    wr_busy = 1'b1; wait_n(4);
    c0 = commits;
    bus_start();
    wbyte(CW, a); chk(!a, "R9 busy write control", a, 0);
    wbyte(8'h00, a); chk(!a, "R9 busy following byte", a, 0);
    bus_stop();
    bus_start();
    wbyte(CR, a); chk(!a, "R9 busy read control", a, 0);
    bus_stop(); wait_n(6);
    chk(commits == c0, "R10 no commit while busy", commits, c0);
    wr_busy = 1'b0; wait_n(4);
    bus_start();
    wbyte(CW, a); chk(a, "R9 ack after busy ends", a, 1);
    bus_stop(); wait_n(6);
    chk(commits == c0, "R10 no commit without data", commits, c0);

    // R1: Start in the middle of a byte
    bus_start();
    for (int i = 7; i >= 4; i--) bit_x(CW[i], r);
    bus_start();
    wbyte(CR, a); chk(a, "R1 mid-byte restart ack", a, 1);
    rd_expect(1'b1, "R1 read after mid-byte restart");
    bus_stop(); wait_n(10);

    chk(exp_wr.size() == 0, "R6 all writes seen", exp_wr.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule